// File: doc/BRIEF.md
# Embedded Sync Video Decoder

This block sits at the front of a video input path that carries its line and frame timing inside the sample stream. It watches each qualified sample for a timing reference: a full-scale word, two zero words, then a flag word. It decodes horizontal blanking, vertical blanking and field identity from that flag word. Every other qualified sample that arrives while neither blanking flag is set is passed on as an active pixel, one cycle later. The first pixel of each line and of each frame is marked.

The sample width is a parameter, 8 or 10 bits. Only the upper eight bits of a sample take part in code detection and flag decoding, so a 10-bit stream carrying 8-bit codes behaves like an 8-bit stream. A data-valid qualifier lets the video clock run faster than the pixel rate. A lock input from the upstream receiver marks every sample invalid while it is low. When lock drops inside a picture, the block closes that picture and waits for fresh timing.

Top module: `esd_decoder`

## Requirements
- R1: A timing reference is recognised when qualified samples arrive with upper byte 0xFF, then 0x00, then 0x00; the next qualified sample is taken as the flag word and updates the decoded flags. None of these four samples is output as a pixel.
- R2: Only the upper eight bits of a sample are used for code matching and flag decoding. With DATA_W=10 the two low bits have no effect on detection.
- R3: Within the upper byte of the flag word, bit 4 is horizontal blanking (hblank), bit 5 is vertical blanking (vblank) and bit 6 is the field flag (fld). Bit 7 and bits 3..0 are ignored. After reset hblank=1, vblank=1 and fld=0.
- R4: A sample is processed only in a cycle where smp_vld=1 and lock=1. Other samples change neither the flags nor the detector, and give no pixel.
- R5: A processed sample that is not part of a timing reference, taken while hblank=0 and vblank=0, appears on pix_data with pix_vld=1 on the following cycle, all DATA_W bits unchanged.
- R6: pix_sol is 1 with the first pixel that follows a flag word with H=0.
- R7: pix_sof is 1 with the first pixel after a flag word that took vblank from 1 to 0. It is cancelled by a later flag word with V=1. fld gives the field of that frame.
- R8: If a partially matched reference is followed by a sample that does not continue it, the detector restarts. That sample is treated as an ordinary sample, or as a new first word if its upper byte is 0xFF.
- R9: In any cycle with lock=0, the detector is cleared, hblank and vblank are forced to 1, and pending line and frame marks are dropped. frm_abort pulses for one cycle, on the next cycle, if vblank was 0.
- R10: While rst_n=0, pix_vld, pix_sol, pix_sof and frm_abort are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_in | input | DATA_W | Incoming video sample |
| smp_vld | input | 1 | Sample qualifier |
| lock | input | 1 | Upstream receiver locked |
| pix_data | output | DATA_W | Active pixel sample |
| pix_vld | output | 1 | pix_data holds a new pixel |
| pix_sol | output | 1 | First pixel of a line |
| pix_sof | output | 1 | First pixel of a frame |
| fld | output | 1 | Decoded field flag |
| hblank | output | 1 | Decoded horizontal blanking flag |
| vblank | output | 1 | Decoded vertical blanking flag |
| frm_abort | output | 1 | Picture closed early by loss of lock |

## Verification
The bench builds the block twice, with DATA_W=10 and with DATA_W=8, and feeds both the same stream; the 8-bit copy gets only the upper byte. The 10-bit copy receives random low bits on every code and pixel word. Code detection that leaks those bits in shows up as a disagreement between the two copies and with the model. Random data-valid gaps carry code-like values, and broken preambles, lock loss in mid-picture and odd field frames exercise the marker and abort corner cases.

// File: rtl/esd_pkg.sv
package esd_pkg;

  localparam int CODE_W = 8;
  localparam logic [CODE_W-1:0] CODE_HI = 8'hFF;
  localparam logic [CODE_W-1:0] CODE_LO = 8'h00;
  localparam int H_POS = 4;
  localparam int V_POS = 5;
  localparam int F_POS = 6;

  typedef enum logic [1:0] {
    TRS_IDLE,
    TRS_GOT_HI,
    TRS_GOT_Z1,
    TRS_GOT_Z2
  } trs_state_e;

  typedef struct packed {
    logic f;
    logic v;
    logic h;
  } tflags_t;

endpackage

// File: rtl/esd_trs_detect.sv
module esd_trs_detect
  import esd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_en,
  input  logic              clr,
  input  logic [CODE_W-1:0] code,
  output logic              xyz_stb,
  output logic              code_smp
);

  trs_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    xyz_stb  = 1'b0;
    code_smp = 1'b0;
    if (clr) begin
      state_d = TRS_IDLE;
    end else if (smp_en) begin
      if (state_q == TRS_GOT_Z2) begin
        xyz_stb  = 1'b1;
        code_smp = 1'b1;
        state_d  = TRS_IDLE;
      end else if (code == CODE_HI) begin
        code_smp = 1'b1;
        state_d  = TRS_GOT_HI;
      end else if (code == CODE_LO && state_q == TRS_GOT_HI) begin
        code_smp = 1'b1;
        state_d  = TRS_GOT_Z1;
      end else if (code == CODE_LO && state_q == TRS_GOT_Z1) begin
        code_smp = 1'b1;
        state_d  = TRS_GOT_Z2;
      end else begin
        state_d = TRS_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= TRS_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/esd_flag_track.sv
module esd_flag_track
  import esd_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    clr,
  input  logic    xyz_stb,
  input  tflags_t xyz,
  input  logic    pix_cand,
  output tflags_t cur,
  output logic    pix_take,
  output logic    mark_sol,
  output logic    mark_sof,
  output logic    frm_open
);

  tflags_t flg_q, flg_d;
  logic    sol_pend_q, sol_pend_d;
  logic    sof_pend_q, sof_pend_d;

  assign cur      = flg_q;
  assign frm_open = ~flg_q.v;
  assign pix_take = pix_cand & ~flg_q.h & ~flg_q.v;
  assign mark_sol = pix_take & sol_pend_q;
  assign mark_sof = pix_take & sof_pend_q;

  always_comb begin
    flg_d      = flg_q;
    sol_pend_d = sol_pend_q;
    sof_pend_d = sof_pend_q;
    if (clr) begin
      flg_d.h    = 1'b1;
      flg_d.v    = 1'b1;
      sol_pend_d = 1'b0;
      sof_pend_d = 1'b0;
    end else if (xyz_stb) begin
      flg_d      = xyz;
      sol_pend_d = ~xyz.h;
      sof_pend_d = xyz.v ? 1'b0 : (flg_q.v | sof_pend_q);
    end else if (pix_take) begin
      sol_pend_d = 1'b0;
      sof_pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q      <= '{f: 1'b0, v: 1'b1, h: 1'b1};
      sol_pend_q <= 1'b0;
      sof_pend_q <= 1'b0;
    end else begin
      flg_q      <= flg_d;
      sol_pend_q <= sol_pend_d;
      sof_pend_q <= sof_pend_d;
    end
  end

endmodule

// File: rtl/esd_decoder.sv
module esd_decoder
  import esd_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] smp_in,
  input  logic              smp_vld,
  input  logic              lock,
  output logic [DATA_W-1:0] pix_data,
  output logic              pix_vld,
  output logic              pix_sol,
  output logic              pix_sof,
  output logic              fld,
  output logic              hblank,
  output logic              vblank,
  output logic              frm_abort
);

  localparam int CODE_LSB = DATA_W - CODE_W;

  logic [CODE_W-1:0] code;
  logic              smp_en, clr;
  logic              xyz_stb, code_smp;
  tflags_t           xyz, cur;
  logic              pix_take, mark_sol, mark_sof, frm_open;

  logic [DATA_W-1:0] pix_data_q;
  logic              pix_vld_q, sol_q, sof_q, abort_q;

  generate
    if (CODE_LSB > 0) begin : g_wide
      assign code = smp_in[DATA_W-1:CODE_LSB];
    end else begin : g_narrow
      assign code = smp_in[CODE_W-1:0];
    end
  endgenerate

  assign smp_en = smp_vld & lock;
  assign clr    = ~lock;
  assign xyz    = '{f: code[F_POS], v: code[V_POS], h: code[H_POS]};

  esd_trs_detect u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_en   (smp_en),
    .clr      (clr),
    .code     (code),
    .xyz_stb  (xyz_stb),
    .code_smp (code_smp)
  );

  esd_flag_track u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .xyz_stb  (xyz_stb),
    .xyz      (xyz),
    .pix_cand (smp_en & ~code_smp),
    .cur      (cur),
    .pix_take (pix_take),
    .mark_sol (mark_sol),
    .mark_sof (mark_sof),
    .frm_open (frm_open)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_vld_q <= 1'b0;
      sol_q     <= 1'b0;
      sof_q     <= 1'b0;
      abort_q   <= 1'b0;
    end else begin
      pix_vld_q <= pix_take;
      sol_q     <= mark_sol;
      sof_q     <= mark_sof;
      abort_q   <= clr & frm_open;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pix_data_q <= '0;
    else if (pix_take) pix_data_q <= smp_in;
  end

  assign pix_data  = pix_data_q;
  assign pix_vld   = pix_vld_q;
  assign pix_sol   = sol_q;
  assign pix_sof   = sof_q;
  assign frm_abort = abort_q;
  assign fld       = cur.f;
  assign hblank    = cur.h;
  assign vblank    = cur.v;

endmodule

// File: rtl/esd_decoder_chk.sv
module esd_decoder_chk #(
  parameter int DATA_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] smp_in,
  input logic              smp_vld,
  input logic              lock,
  input logic [DATA_W-1:0] pix_data,
  input logic              pix_vld,
  input logic              pix_sol,
  input logic              pix_sof,
  input logic              fld,
  input logic              hblank,
  input logic              vblank,
  input logic              frm_abort
);

  // R4: an unqualified cycle never yields a pixel
  assert_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp_vld && lock) |=> !pix_vld);

  // R4: a locked cycle without data-valid leaves the flags alone
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_vld && lock) |=> ($stable(hblank) && $stable(vblank) && $stable(fld)));

  // R5: pixels only come out of the active area
  assert_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pix_vld |-> (!hblank && !vblank));

  // R5: the pixel is the sample taken one cycle earlier
  assert_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pix_vld |-> (pix_data == $past(smp_in)));

  // R6: a line mark rides on a pixel
  assert_sol_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pix_sol |-> pix_vld);

  // R7: a frame mark rides on a pixel
  assert_sof_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pix_sof |-> pix_vld);

  // R9: without lock the picture is closed
  assert_unlock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !lock |=> (hblank && vblank && !pix_vld));

  // R9: abort only follows an unlocked cycle inside a picture
  assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frm_abort |-> ($past(!lock) && $past(!vblank)));

endmodule

bind esd_decoder esd_decoder_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_in    (smp_in),
  .smp_vld   (smp_vld),
  .lock      (lock),
  .pix_data  (pix_data),
  .pix_vld   (pix_vld),
  .pix_sol   (pix_sol),
  .pix_sof   (pix_sof),
  .fld       (fld),
  .hblank    (hblank),
  .vblank    (vblank),
  .frm_abort (frm_abort)
);

// File: tb/esd_decoder_tb_top.sv
module esd_decoder_tb_top;

  localparam int CLK_P = 10;
  localparam int WDOG_CYC = 200000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [9:0] smp10;
  logic       vld_i, lock_i;

  logic [9:0] d10_data;
  logic [7:0] d8_data;
  logic       d10_vld, d10_sol, d10_sof, d10_fld, d10_hb, d10_vb, d10_ab;
  logic       d8_vld, d8_sol, d8_sof, d8_fld, d8_hb, d8_vb, d8_ab;

  int checks = 0;
  int errs = 0;
  int gap_pct = 0;
  string scen = "R10 reset";

  // reference model state
  int         m_st;
  logic       m_h, m_v, m_f, m_solp, m_sofp;
  logic       e_vld, e_sol, e_sof, e_abort;
  logic [9:0] e_data;

  always #(CLK_P/2) clk = ~clk;

  esd_decoder #(.DATA_W(10)) dut_i (
    .clk(clk), .rst_n(rst_n), .smp_in(smp10), .smp_vld(vld_i), .lock(lock_i),
    .pix_data(d10_data), .pix_vld(d10_vld), .pix_sol(d10_sol), .pix_sof(d10_sof),
    .fld(d10_fld), .hblank(d10_hb), .vblank(d10_vb), .frm_abort(d10_ab)
  );

  esd_decoder #(.DATA_W(8)) dut8_i (
    .clk(clk), .rst_n(rst_n), .smp_in(smp10[9:2]), .smp_vld(vld_i), .lock(lock_i),
    .pix_data(d8_data), .pix_vld(d8_vld), .pix_sol(d8_sol), .pix_sof(d8_sof),
    .fld(d8_fld), .hblank(d8_hb), .vblank(d8_vb), .frm_abort(d8_ab)
  );

  task automatic chk(input string req, input logic [9:0] got, input logic [9:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s [%s]: got %h expected %h at %0t", req, scen, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R5 pix_vld w10", {9'd0, d10_vld}, {9'd0, e_vld});
    chk("R5 pix_vld w8",  {9'd0, d8_vld},  {9'd0, e_vld});
    if (e_vld) begin
      chk("R5 pix_data w10", d10_data, e_data);
      chk("R2 pix_data w8", {2'b00, d8_data}, {2'b00, e_data[9:2]});
    end
    chk("R6 pix_sol w10", {9'd0, d10_sol}, {9'd0, e_sol});
    chk("R6 pix_sol w8",  {9'd0, d8_sol},  {9'd0, e_sol});
    chk("R7 pix_sof w10", {9'd0, d10_sof}, {9'd0, e_sof});
    chk("R7 pix_sof w8",  {9'd0, d8_sof},  {9'd0, e_sof});
    chk("R7 fld",         {8'd0, d10_fld, d8_fld}, {8'd0, m_f, m_f});
    chk("R3 hblank",      {8'd0, d10_hb, d8_hb},   {8'd0, m_h, m_h});
    chk("R3 vblank",      {8'd0, d10_vb, d8_vb},   {8'd0, m_v, m_v});
    chk("R9 frm_abort",   {8'd0, d10_ab, d8_ab},   {8'd0, e_abort, e_abort});
  endtask

  task automatic model_step(input logic [9:0] d, input logic vld, input logic lk);
    logic [7:0] c;
    c = d[9:2];
    e_vld = 1'b0; e_sol = 1'b0; e_sof = 1'b0; e_abort = 1'b0;
    if (!lk) begin
      e_abort = !m_v;
      m_st = 0; m_h = 1'b1; m_v = 1'b1; m_solp = 1'b0; m_sofp = 1'b0;
    end else if (vld) begin
      if (m_st == 3) begin
        if (c[5]) m_sofp = 1'b0;
        else if (m_v) m_sofp = 1'b1;
        m_solp = !c[4];
        m_h = c[4]; m_v = c[5]; m_f = c[6];
        m_st = 0;
      end else if (c == 8'hFF) begin
        m_st = 1;
      end else if (c == 8'h00 && (m_st == 1 || m_st == 2)) begin
        m_st = m_st + 1;
      end else begin
        m_st = 0;
        if (!m_h && !m_v) begin
          e_vld = 1'b1; e_data = d; e_sol = m_solp; e_sof = m_sofp;
          m_solp = 1'b0; m_sofp = 1'b0;
        end
      end
    end
  endtask

  task automatic cyc(input logic [9:0] d, input logic vld, input logic lk);
    @(negedge clk);
    compare_all();
    smp10 = d; vld_i = vld; lock_i = lk;
    model_step(d, vld, lk);
  endtask

  function automatic logic [9:0] junk();
    logic [9:0] r;
    r = 10'($urandom);
    if ($urandom_range(3) == 0) r[9:2] = 8'hFF;
    else if ($urandom_range(3) == 0) r[9:2] = 8'h00;
    return r;
  endfunction

  // qualified sample, preceded by random unqualified cycles (R4)
  task automatic put(input logic [7:0] c);
    while ($urandom_range(99) < gap_pct) cyc(junk(), 1'b0, 1'b1);
    cyc({c, 2'($urandom)}, 1'b1, 1'b1);
  endtask

  function automatic logic [7:0] rpix();
    return 8'($urandom_range(1, 254));
  endfunction

  // R1 / R3: bit 7 and bits 3..0 of the flag byte are randomised
  task automatic send_trs(input logic h, input logic v, input logic f);
    put(8'hFF); put(8'h00); put(8'h00);
    put({1'($urandom), f, v, h, 4'($urandom)});
  endtask

  task automatic line(input logic v, input logic f, input int blank_n, input int act_n);
    send_trs(1'b1, v, f);
    for (int i = 0; i < blank_n; i++) put(rpix());
    send_trs(1'b0, v, f);
    for (int i = 0; i < act_n; i++) put(rpix());
  endtask

  task automatic frame(input logic f, input int vb_lines, input int act_lines, input int w);
    for (int i = 0; i < vb_lines; i++) line(1'b1, f, 3, w);
    for (int i = 0; i < act_lines; i++) line(1'b0, f, 3, w);
  endtask

  initial begin
    rst_n = 1'b0; smp10 = '0; vld_i = 1'b0; lock_i = 1'b0;
    m_st = 0; m_h = 1'b1; m_v = 1'b1; m_f = 1'b0; m_solp = 1'b0; m_sofp = 1'b0;
    e_vld = 1'b0; e_sol = 1'b0; e_sof = 1'b0; e_abort = 1'b0; e_data = '0;

    // R10: reset state with active-looking input
    repeat (3) @(negedge clk);
    smp10 = 10'h155; vld_i = 1'b1; lock_i = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 outputs in reset", {6'd0, d10_vld, d10_sol, d10_sof, d10_ab}, 10'd0);
    chk("R10 flags in reset", {7'd0, d10_hb, d10_vb, d10_fld}, 10'b110);
    @(negedge clk);
    rst_n = 1'b1; vld_i = 1'b0;

    scen = "R1 frame decode";
    frame(1'b0, 2, 3, 8);
    scen = "R7 odd field";
    frame(1'b1, 1, 2, 6);

    scen = "R4 data-valid gaps";
    gap_pct = 40;
    frame(1'b0, 1, 3, 10);

    scen = "R8 partial preamble";
    gap_pct = 20;
    send_trs(1'b1, 1'b1, 1'b0);
    send_trs(1'b0, 1'b0, 1'b0);
    put(rpix()); put(8'hFF); put(8'h00); put(8'h5A); put(rpix());
    put(8'hFF); put(8'h33); put(rpix());
    put(8'hFF); put(8'h00); put(8'hFF); put(8'h00); put(8'h00);
    put({1'b1, 1'b0, 1'b0, 1'b1, 4'h3});
    put(rpix()); put(rpix());
    send_trs(1'b0, 1'b0, 1'b0);
    put(rpix()); put(rpix());

    scen = "R9 lock loss";
    for (int i = 0; i < 3; i++) cyc(junk(), 1'($urandom), 1'b0);
    put(rpix()); put(rpix());
    send_trs(1'b0, 1'b0, 1'b0);
    put(rpix()); put(rpix());
    for (int i = 0; i < 2; i++) cyc(junk(), 1'b1, 1'b0);
    frame(1'b1, 1, 2, 5);

    scen = "R2 final";
    gap_pct = 0;
    frame(1'b0, 1, 2, 4);
    for (int i = 0; i < 3; i++) cyc(junk(), 1'b0, 1'b1);
    @(negedge clk);
    compare_all();

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule